// File: doc/BRIEF.md
# Branch Condition and Counter Unit

This unit resolves conditional branches for a simple in-order core. Each request carries a five-bit option field, a five-bit index into a 32-bit condition vector, a link flag, the address of the branch, a precomputed relative target, a target kind (relative, through the link register, through the count register) and a width-mode flag. The unit holds the 64-bit count and link registers. It decides whether the branch is taken and returns the next fetch address. It also updates both registers as a side effect.

Requests arrive on a valid/ready channel, and resolved results leave on a second valid/ready channel. The input accepts a request when `req_valid && req_ready`. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A result stays on the output, unchanged, until `res_ready` is seen high. Back-pressure therefore stalls the input after one result is held.

Move-to ports load either register directly, and the current register values are always visible on the move-from outputs. If an accepted branch and a move-to write target the same register in the same cycle, the branch update wins.

Top module: `bcu_branch_unit`

## Requirements
- R1: While reset is asserted, `res_valid` is 0 and both `ctr_q` and `lr_q` read 0.
- R2: `req_ready` equals `!res_valid || res_ready`. A held result (`res_valid && !res_ready`) keeps all result fields unchanged. Results leave in acceptance order, one result per accepted request.
- R3: Option bit `req_bo[4]` = 1 ignores the condition. Otherwise the branch requires `cond_vec[req_bi]` (index 0 is the LSB) to equal `req_bo[3]`. `req_bo[0]` is a hint and has no effect.
- R4: Option value 5'b10100 always branches, whatever the condition bit and the count, and it leaves the count register unchanged.
- R5: When `req_bo[2]` = 0, the count register is decremented by one across all 64 bits, wrapping from 0 to all ones. The branch then also requires the decremented value to be zero (`req_bo[1]` = 1) or nonzero (`req_bo[1]` = 0).
- R6: With `req_mode64` = 0, the zero test looks only at bits 31:0 of the decremented count. With `req_mode64` = 1, it looks at all 64 bits.
- R7: Option value 5'b00000 branches only when the decremented count is nonzero and the selected condition bit is 0.
- R8: A taken branch yields the kind's target: `req_tgt` for kind 0 (relative) and kind 3, the link register for kind 1, the count register for kind 2. A branch that is not taken yields `req_pc + 4`.
- R9: Targets taken from the link or count register have bits 1:0 forced to zero.
- R10: When `req_lk` = 1, the link register is loaded with `req_pc + 4`, whether or not the branch is taken. A kind-1 branch uses the link value from before that update.
- R11: A kind-2 request with `req_bo[2]` = 0 sets `res_illegal`. The count register is not decremented, and the count test counts as satisfied.
- R12: `mtctr_en` or `mtlr_en` loads the data on that port into the register at the clock edge, and `ctr_q`/`lr_q` show the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Branch request present |
| req_ready | output | 1 | Unit can accept a request |
| req_bo | input | 5 | Branch option field |
| req_bi | input | 5 | Condition bit index |
| req_lk | input | 1 | Write return address to link register |
| req_pc | input | 64 | Address of the branch |
| req_tgt | input | 64 | Precomputed relative target |
| req_kind | input | 2 | Target kind: 0 relative, 1 link, 2 count, 3 relative |
| req_mode64 | input | 1 | 1: 64-bit zero test, 0: low 32 bits |
| cond_vec | input | 32 | Condition vector |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer accepts result |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 64 | Next fetch address |
| res_illegal | output | 1 | Illegal count-target decrement |
| mtctr_en | input | 1 | Load count register |
| mtctr_data | input | 64 | Count load value |
| mtlr_en | input | 1 | Load link register |
| mtlr_data | input | 64 | Link load value |
| ctr_q | output | 64 | Current count register |
| lr_q | output | 64 | Current link register |

## Verification
The properties assume that request fields are stable while the request is accepted, and that a move-to write to the count register does not coincide with an illegal count-target request. The bench drives a request only from one negative edge to the next, and it issues move-to writes only while no request is valid, so neither assumption is broken. The `res_ready` pattern inserts stalls regularly. This exercises the hold rule without ever holding the output forever.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [1:0] {
    BK_REL   = 2'd0,
    BK_LINK  = 2'd1,
    BK_COUNT = 2'd2,
    BK_REL2  = 2'd3
  } br_kind_e;

  // option field bit positions
  localparam int unsigned OPT_NO_COND   = 4;
  localparam int unsigned OPT_COND_VAL  = 3;
  localparam int unsigned OPT_NO_COUNT  = 2;
  localparam int unsigned OPT_WANT_ZERO = 1;
endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned CVEC     = 32,
  parameter int unsigned NARROW_W = 32,
  localparam int unsigned BI_W    = $clog2(CVEC)
) (
  input  logic [4:1]      opt,
  input  logic [BI_W-1:0] sel,
  input  logic [CVEC-1:0] cond_vec,
  input  br_kind_e        kind,
  input  logic            mode_wide,
  input  logic [XLEN-1:0] ctr_cur,
  output logic [XLEN-1:0] ctr_dec,
  output logic            dec_en,
  output logic            illegal,
  output logic            taken
);
  logic cond_ok;
  logic cnt_ok;
  logic dec_zero;

  assign cond_ok = opt[OPT_NO_COND] | (cond_vec[sel] == opt[OPT_COND_VAL]);
  assign illegal = (kind == BK_COUNT) && !opt[OPT_NO_COUNT];
  assign dec_en  = !opt[OPT_NO_COUNT] && !illegal;
  assign ctr_dec = ctr_cur - XLEN'(1);

  generate
    if (XLEN > NARROW_W) begin : g_split
      assign dec_zero = mode_wide ? (ctr_dec == '0)
                                  : (ctr_dec[NARROW_W-1:0] == '0);
    end else begin : g_flat
      logic unused_mode;
      assign unused_mode = mode_wide;
      assign dec_zero = (ctr_dec == '0);
    end
  endgenerate

  assign cnt_ok = !dec_en || (dec_zero == opt[OPT_WANT_ZERO]);
  assign taken  = cond_ok && cnt_ok;
endmodule

// File: rtl/bcu_spr_regs.sv
module bcu_spr_regs #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_fire,
  input  logic            dec_en,
  input  logic [XLEN-1:0] ctr_dec,
  input  logic            link_en,
  input  logic [XLEN-1:0] link_val,
  input  logic            mtctr_en,
  input  logic [XLEN-1:0] mtctr_data,
  input  logic            mtlr_en,
  input  logic [XLEN-1:0] mtlr_data,
  output logic [XLEN-1:0] ctr_q,
  output logic [XLEN-1:0] lr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr_q <= '0;
    end else if (br_fire && dec_en) begin
      ctr_q <= ctr_dec;
    end else if (mtctr_en) begin
      ctr_q <= mtctr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q <= '0;
    end else if (br_fire && link_en) begin
      lr_q <= link_val;
    end else if (mtlr_en) begin
      lr_q <= mtlr_data;
    end
  end
endmodule

// File: rtl/bcu_out_stage.sv
module bcu_out_stage #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_taken,
  input  logic [XLEN-1:0] in_pc,
  input  logic            in_illegal,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_taken,
  output logic [XLEN-1:0] out_pc,
  output logic            out_illegal
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_taken   <= 1'b0;
      out_pc      <= '0;
      out_illegal <= 1'b0;
    end else if (load) begin
      out_taken   <= in_taken;
      out_pc      <= in_pc;
      out_illegal <= in_illegal;
    end
  end
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
  import bcu_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned CVEC       = 32,
  parameter int unsigned NARROW_W   = 32,
  parameter int unsigned INSN_BYTES = 4,
  localparam int unsigned BI_W      = $clog2(CVEC),
  localparam int unsigned ALIGN_W   = $clog2(INSN_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [4:0]      req_bo,
  input  logic [BI_W-1:0] req_bi,
  input  logic            req_lk,
  input  logic [XLEN-1:0] req_pc,
  input  logic [XLEN-1:0] req_tgt,
  input  logic [1:0]      req_kind,
  input  logic            req_mode64,
  input  logic [CVEC-1:0] cond_vec,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_taken,
  output logic [XLEN-1:0] res_next_pc,
  output logic            res_illegal,
  input  logic            mtctr_en,
  input  logic [XLEN-1:0] mtctr_data,
  input  logic            mtlr_en,
  input  logic [XLEN-1:0] mtlr_data,
  output logic [XLEN-1:0] ctr_q,
  output logic [XLEN-1:0] lr_q
);
  br_kind_e        kind;
  logic            fire;
  logic            taken;
  logic            illegal;
  logic            dec_en;
  logic [XLEN-1:0] ctr_dec;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] reg_tgt;
  logic [XLEN-1:0] next_pc;
  logic            unused_hint;

  assign unused_hint = req_bo[0];
  assign kind        = br_kind_e'(req_kind);
  assign fire        = req_valid && req_ready;
  assign seq_pc      = req_pc + XLEN'(INSN_BYTES);

  bcu_cond_eval #(
    .XLEN(XLEN), .CVEC(CVEC), .NARROW_W(NARROW_W)
  ) u_eval (
    .opt      (req_bo[4:1]),
    .sel      (req_bi),
    .cond_vec (cond_vec),
    .kind     (kind),
    .mode_wide(req_mode64),
    .ctr_cur  (ctr_q),
    .ctr_dec  (ctr_dec),
    .dec_en   (dec_en),
    .illegal  (illegal),
    .taken    (taken)
  );

  // register-held targets are aligned to an instruction boundary
  always_comb begin
    reg_tgt = (kind == BK_LINK) ? lr_q : ctr_q;
    reg_tgt[ALIGN_W-1:0] = '0;
  end

  always_comb begin
    next_pc = seq_pc;
    if (taken) begin
      unique case (kind)
        BK_LINK, BK_COUNT: next_pc = reg_tgt;
        default:           next_pc = req_tgt;
      endcase
    end
  end

  bcu_spr_regs #(.XLEN(XLEN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_fire   (fire),
    .dec_en    (dec_en),
    .ctr_dec   (ctr_dec),
    .link_en   (req_lk),
    .link_val  (seq_pc),
    .mtctr_en  (mtctr_en),
    .mtctr_data(mtctr_data),
    .mtlr_en   (mtlr_en),
    .mtlr_data (mtlr_data),
    .ctr_q     (ctr_q),
    .lr_q      (lr_q)
  );

  bcu_out_stage #(.XLEN(XLEN)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_ready   (req_ready),
    .in_taken   (taken),
    .in_pc      (next_pc),
    .in_illegal (illegal),
    .out_valid  (res_valid),
    .out_ready  (res_ready),
    .out_taken  (res_taken),
    .out_pc     (res_next_pc),
    .out_illegal(res_illegal)
  );
endmodule

// File: rtl/bcu_branch_unit_chk.sv
module bcu_branch_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [4:0]      req_bo,
  input logic            req_lk,
  input logic [XLEN-1:0] req_pc,
  input logic [1:0]      req_kind,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_taken,
  input logic [XLEN-1:0] res_next_pc,
  input logic            res_illegal,
  input logic            mtctr_en,
  input logic [XLEN-1:0] ctr_q,
  input logic [XLEN-1:0] lr_q
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_next_pc)
                                   && $stable(res_taken) && $stable(res_illegal)));

  assert_always_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_bo == 5'b10100) |=> (res_taken && ctr_q == $past(ctr_q)));

  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_bo[2] && req_kind != 2'd2) |=> (ctr_q == $past(ctr_q) - XLEN'(1)));

  assert_fallthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (res_taken || res_next_pc == $past(req_pc) + XLEN'(4)));

  assert_link_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd1) |=>
      (!res_taken || res_next_pc == ($past(lr_q) & ~XLEN'(3))));

  assert_link_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_lk) |=> (lr_q == $past(req_pc) + XLEN'(4)));

  assert_illegal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd2 && !req_bo[2] && !mtctr_en) |=>
      (res_illegal && ctr_q == $past(ctr_q)));
endmodule

bind bcu_branch_unit bcu_branch_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bo(req_bo), .req_lk(req_lk), .req_pc(req_pc), .req_kind(req_kind),
  .res_valid(res_valid), .res_ready(res_ready), .res_taken(res_taken),
  .res_next_pc(res_next_pc), .res_illegal(res_illegal),
  .mtctr_en(mtctr_en), .ctr_q(ctr_q), .lr_q(lr_q)
);

// File: tb/bcu_branch_unit_tb.sv
module bcu_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_bo = '0;
  logic [4:0]  req_bi = '0;
  logic        req_lk = 1'b0;
  logic [63:0] req_pc = '0;
  logic [63:0] req_tgt = '0;
  logic [1:0]  req_kind = '0;
  logic        req_mode64 = 1'b1;
  logic [31:0] cond_vec = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_taken;
  logic [63:0] res_next_pc;
  logic        res_illegal;
  logic        mtctr_en = 1'b0;
  logic [63:0] mtctr_data = '0;
  logic        mtlr_en = 1'b0;
  logic [63:0] mtlr_data = '0;
  logic [63:0] ctr_q;
  logic [63:0] lr_q;

  int checks = 0;
  int errors = 0;
  bit bp_force = 1'b0;

  typedef struct {
    logic        taken;
    logic [63:0] pc;
    logic        illegal;
    string       tag;
  } exp_t;
  exp_t scb[$];

  logic [63:0] ctr_m = '0;
  logic [63:0] lr_m  = '0;

  always #4 clk = ~clk;

  bcu_branch_unit dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // output consumer with periodic stalls
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      res_ready <= bp_force ? 1'b0 : ((cyc % 5) != 2);
    end
  end

  // monitor: pop and compare at each output handshake
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid && res_ready) begin
        if (scb.size() == 0) begin
          check(1'b0, "R2 unexpected result", res_next_pc, '0);
        end else begin
          exp_t e;
          e = scb.pop_front();
          check(res_taken == e.taken, {e.tag, " taken"}, 64'(res_taken), 64'(e.taken));
          check(res_next_pc == e.pc, {e.tag, " next_pc"}, res_next_pc, e.pc);
          check(res_illegal == e.illegal, {e.tag, " illegal"}, 64'(res_illegal),
                64'(e.illegal));
        end
      end
    end
  end

  task automatic send(input logic [4:0] bo, input logic [4:0] bi, input logic lk,
                      input logic [63:0] pc, input logic [63:0] tgt,
                      input logic [1:0] kind, input logic m64,
                      input logic [31:0] cv, input string tag);
    exp_t e;
    logic ill, dec, cok, nok, z;
    logic [63:0] d, t;
    cok = bo[4] || (cv[bi] == bo[3]);
    ill = (kind == 2'd2) && !bo[2];
    dec = !bo[2] && !ill;
    d   = ctr_m - 64'd1;
    z   = m64 ? (d == 64'd0) : (d[31:0] == 32'd0);
    nok = !dec || (z == bo[1]);
    e.taken = cok && nok;
    t = (kind == 2'd1) ? (lr_m & ~64'd3) : (kind == 2'd2) ? (ctr_m & ~64'd3) : tgt;
    e.pc = e.taken ? t : pc + 64'd4;
    e.illegal = ill;
    e.tag = tag;
    scb.push_back(e);
    if (dec) ctr_m = d;
    if (lk) lr_m = pc + 64'd4;
    @(negedge clk);
    req_valid = 1'b1; req_bo = bo; req_bi = bi; req_lk = lk; req_pc = pc;
    req_tgt = tgt; req_kind = kind; req_mode64 = m64; cond_vec = cv;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load_ctr(input logic [63:0] v);
    @(negedge clk);
    mtctr_en = 1'b1; mtctr_data = v;
    @(negedge clk);
    mtctr_en = 1'b0;
    ctr_m = v;
  endtask

  task automatic load_lr(input logic [63:0] v);
    @(negedge clk);
    mtlr_en = 1'b1; mtlr_data = v;
    @(negedge clk);
    mtlr_en = 1'b0;
    lr_m = v;
  endtask

  task automatic regs_match(input string tag);
    check(ctr_q == ctr_m, {tag, " ctr"}, ctr_q, ctr_m);
    check(lr_q == lr_m, {tag, " lr"}, lr_q, lr_m);
  endtask

  task automatic drain();
    while (scb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", scb.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(res_valid == 1'b0, "R1 res_valid", 64'(res_valid), 0);
    check(ctr_q == 0, "R1 ctr_q", ctr_q, 0);
    check(lr_q == 0, "R1 lr_q", lr_q, 0);
    rst_n = 1'b1;

    // R12: move-to loads
    load_ctr(64'd3);
    load_lr(64'h0000_0000_0000_2003);
    regs_match("R12");

    // R4: always form ignores condition and count
    send(5'b10100, 5'd7, 0, 64'h1000, 64'h4000, 2'd0, 1, 32'h0, "R4 always cond0");
    send(5'b10101, 5'd7, 0, 64'h1004, 64'h4100, 2'd3, 1, 32'hFFFF_FFFF, "R4 always hint");
    regs_match("R4");

    // R3: condition polarity
    send(5'b01100, 5'd5, 0, 64'h1100, 64'h5000, 2'd0, 1, 32'h0000_0020, "R3 need1 have1");
    send(5'b01100, 5'd5, 0, 64'h1104, 64'h5000, 2'd0, 1, 32'hFFFF_FFDF, "R3 need1 have0");
    send(5'b00100, 5'd31, 0, 64'h1108, 64'h5100, 2'd0, 1, 32'h7FFF_FFFF, "R3 need0 have0");
    send(5'b00101, 5'd31, 0, 64'h110C, 64'h5100, 2'd0, 1, 32'h8000_0000, "R3 need0 have1");

    // R5: count loop, ctr 3 -> 2,1 taken, 0 falls through
    send(5'b10000, 5'd0, 0, 64'h1200, 64'h1180, 2'd0, 1, 0, "R5 loop1");
    send(5'b10000, 5'd0, 0, 64'h1200, 64'h1180, 2'd0, 1, 0, "R5 loop2");
    send(5'b10000, 5'd0, 0, 64'h1200, 64'h1180, 2'd0, 1, 0, "R5 loop3 exit");
    regs_match("R5 after loop");
    send(5'b10000, 5'd0, 0, 64'h1300, 64'h1280, 2'd0, 1, 0, "R5 wrap");
    check(ctr_q == 64'hFFFF_FFFF_FFFF_FFFF, "R5 wrap value", ctr_q, 64'hFFFF_FFFF_FFFF_FFFF);
    load_ctr(64'd1);
    send(5'b10010, 5'd0, 0, 64'h1400, 64'h1380, 2'd0, 1, 0, "R5 want zero");

    // R6: width of the zero test
    load_ctr(64'h1_0000_0001);
    send(5'b10000, 5'd0, 0, 64'h1500, 64'h1480, 2'd0, 0, 0, "R6 narrow low zero");
    check(ctr_q == 64'h1_0000_0000, "R6 full decrement", ctr_q, 64'h1_0000_0000);
    load_ctr(64'h1_0000_0001);
    send(5'b10000, 5'd0, 0, 64'h1504, 64'h1480, 2'd0, 1, 0, "R6 wide nonzero");

    // R7: combined count and condition exit
    load_ctr(64'd5);
    send(5'b00000, 5'd2, 0, 64'h1600, 64'h1580, 2'd0, 1, 32'h0, "R7 cond0 cnt4");
    send(5'b00000, 5'd2, 0, 64'h1604, 64'h1580, 2'd0, 1, 32'h4, "R7 cond1 exit");
    load_ctr(64'd1);
    send(5'b00000, 5'd2, 0, 64'h1608, 64'h1580, 2'd0, 1, 32'h0, "R7 cnt0 exit");

    // R8/R9/R10: link and count targets, link write
    load_lr(64'h0000_0000_0000_7007);
    send(5'b10100, 5'd0, 1, 64'h1700, 64'h0, 2'd1, 1, 0, "R10 link old target R9");
    check(lr_q == 64'h1704, "R10 link written", lr_q, 64'h1704);
    send(5'b01100, 5'd1, 1, 64'h1800, 64'h9000, 2'd0, 1, 32'h0, "R10 untaken R8");
    check(lr_q == 64'h1804, "R10 link on untaken", lr_q, 64'h1804);
    load_ctr(64'h0000_0000_0000_8aaa);
    send(5'b10100, 5'd0, 0, 64'h1900, 64'h0, 2'd2, 1, 0, "R9 count target R8");

    // R11: illegal decrement through count register
    send(5'b10000, 5'd0, 0, 64'h1A00, 64'h0, 2'd2, 1, 0, "R11 illegal");
    check(ctr_q == 64'h8aaa, "R11 ctr kept", ctr_q, 64'h8aaa);

    // R2: back-pressure hold
    drain();
    bp_force = 1'b1;
    send(5'b10100, 5'd0, 0, 64'h1B00, 64'h3330, 2'd0, 1, 0, "R2 held");
    repeat (3) @(negedge clk);
    check(res_valid == 1'b1, "R2 valid held", 64'(res_valid), 1);
    check(res_next_pc == 64'h3330, "R2 data held", res_next_pc, 64'h3330);
    check(req_ready == 1'b0, "R2 ready low", 64'(req_ready), 0);
    bp_force = 1'b0;
    drain();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule